// File: doc/BRIEF.md
# Accumulator Register-Transfer Datapath

This block is the execute half of a very small processor. It holds an accumulator, one general-purpose register and a registered output port. On every rising clock edge where the valid strobe is high, it carries out one of ten register-transfer instructions selected by a 4-bit code. These instructions load registers from the input bus, copy the accumulator into the general register, drive the output port from either register, or combine the two registers in an ALU and write the result back into the accumulator.

Instruction fetch, sequencing and branching belong to the surrounding logic, which presents one instruction code and one input word per cycle. The data width is set by a parameter. The accumulator is the only register that receives ALU results. The output port reads only the two registers, so the block has no direct path from the input bus to the output.

Top module: `acc_datapath`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator, the general register and the output port to zero.
- R2: With valid high, code 1 and code 6 (the code is the 4-bit binary value of the instruction number) each load the accumulator from the input bus.
- R3: With valid high, code 2 copies the accumulator into the general register, and code 5 loads the general register from the input bus.
- R4: With valid high, code 3 writes the general register to the output port, and code 4 writes the accumulator to the output port.
- R5: With valid high, code 7 writes the sum of the accumulator and the general register into the accumulator, modulo 2^W, and keeps no carry.
- R6: With valid high, code 8 writes the bitwise OR and code 9 writes the bitwise AND of the accumulator and the general register into the accumulator.
- R7: With valid high, code 10 writes the bitwise complement of the accumulator into the accumulator.
- R8: The general register keeps its value under every code other than 2 and 5.
- R9: The accumulator keeps its value under codes 2, 3, 4 and 5.
- R10: The output port changes only under codes 3 and 4.
- R11: Codes 0 and 11 through 15 leave all three registers unchanged.
- R12: While valid is low, no register changes, whatever the code and the input bus hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all updates happen on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | High to execute op_i in this cycle |
| op_i | input | 4 | Instruction code, 1 through 10; all other values are no-operations |
| data_i | input | W | Input bus |
| out_o | output | W | Registered output port |

## Verification
A register can be written at one edge and read by the next instruction. The bench therefore issues dependent instructions back to back: an ALU write to the accumulator followed at once by code 4, and a load of the general register followed at once by code 3. The output must show the freshly written value one cycle later and not the stale one. A scoreboard queues the expected output value after every instruction, including instructions that must not touch the output, and compares it at the following falling edge. Non-output instructions are thus judged as well as output instructions.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDI  = 4'd1,
    OP_A2R  = 4'd2,
    OP_OUTR = 4'd3,
    OP_OUTA = 4'd4,
    OP_LDR  = 4'd5,
    OP_LDA  = 4'd6,
    OP_ADD  = 4'd7,
    OP_OR   = 4'd8,
    OP_AND  = 4'd9,
    OP_NOT  = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    FN_PASS,
    FN_ADD,
    FN_OR,
    FN_AND,
    FN_NOT
  } alu_fn_e;

  typedef struct packed {
    logic    a_we;
    logic    r_we;
    logic    o_we;
    logic    r_from_in;
    logic    o_from_r;
    alu_fn_e fn;
  } ctrl_t;
endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
  import acc_pkg::*;
(
  input  logic       valid_i,
  input  logic [3:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{a_we: 1'b0, r_we: 1'b0, o_we: 1'b0,
               r_from_in: 1'b0, o_from_r: 1'b0, fn: FN_PASS};
    if (valid_i) begin
      unique case (op_i)
        OP_LDI, OP_LDA: ctrl_o.a_we = 1'b1;
        OP_A2R:  ctrl_o.r_we = 1'b1;
        OP_LDR: begin
          ctrl_o.r_we      = 1'b1;
          ctrl_o.r_from_in = 1'b1;
        end
        OP_OUTR: begin
          ctrl_o.o_we     = 1'b1;
          ctrl_o.o_from_r = 1'b1;
        end
        OP_OUTA: ctrl_o.o_we = 1'b1;
        OP_ADD: begin ctrl_o.a_we = 1'b1; ctrl_o.fn = FN_ADD; end
        OP_OR:  begin ctrl_o.a_we = 1'b1; ctrl_o.fn = FN_OR;  end
        OP_AND: begin ctrl_o.a_we = 1'b1; ctrl_o.fn = FN_AND; end
        OP_NOT: begin ctrl_o.a_we = 1'b1; ctrl_o.fn = FN_NOT; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = a_i + r_i;  // wraps, carry dropped
      FN_OR:   y_o = a_i | r_i;
      FN_AND:  y_o = a_i & r_i;
      FN_NOT:  y_o = ~a_i;
      default: y_o = in_i;
    endcase
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] out_o
);
  ctrl_t        ctrl;
  logic [W-1:0] a_q, r_q, o_q, alu_y, r_d, o_d;

  acc_decoder u_dec (.valid_i(valid_i), .op_i(op_i), .ctrl_o(ctrl));

  acc_alu #(.W(W)) u_alu (
    .fn_i(ctrl.fn), .a_i(a_q), .r_i(r_q), .in_i(data_i), .y_o(alu_y)
  );

  assign r_d = ctrl.r_from_in ? data_i : a_q;
  assign o_d = ctrl.o_from_r  ? r_q    : a_q;

  acc_reg #(.W(W)) u_a (.clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl.a_we), .d_i(alu_y), .q_o(a_q));
  acc_reg #(.W(W)) u_r (.clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl.r_we), .d_i(r_d),   .q_o(r_q));
  acc_reg #(.W(W)) u_o (.clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl.o_we), .d_i(o_d),   .q_o(o_q));

  assign out_o = o_q;

  // R8 R11 R12
  r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i == 4'd2 || op_i == 4'd5)) |=> $stable(r_q));

  // R9 R11 R12
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i == 4'd1 || (op_i >= 4'd6 && op_i <= 4'd10))) |=> $stable(a_q));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i == 4'd3 || op_i == 4'd4)) |=> $stable(out_o));

  // R3
  r_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd2) |=> (r_q == $past(a_q)));

  // R4
  out_from_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd4) |=> (out_o == $past(a_q)));

  // R7
  a_not_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd10) |=> ((a_q ^ $past(a_q)) == {W{1'b1}}));
endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  logic [W-1:0] ma = '0, mr = '0, mo = '0;

  acc_datapath #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid),
    .op_i(op), .data_i(din), .out_o(out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (out !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, out, it.exp);
      end
    end
  end

  // driver
  task automatic run(input logic v, input logic [3:0] c, input logic [W-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    valid = v; op = c; din = d;
    @(posedge clk);
    if (v) begin
      case (c)
        4'd1, 4'd6: ma = d;
        4'd2:  mr = ma;
        4'd5:  mr = d;
        4'd3:  mo = mr;
        4'd4:  mo = ma;
        4'd7:  ma = ma + mr;
        4'd8:  ma = ma | mr;
        4'd9:  ma = ma & mr;
        4'd10: ma = ~ma;
        default: ;
      endcase
    end
    it.exp = mo; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out !== '0) begin
      errors++;
      $display("FAIL R1: actual=%h expected=00", out);
    end
    rst_ni = 1'b1;
    run(1, 4'd3, 8'hEE, "R1");
    run(1, 4'd4, 8'hEE, "R1");

    run(1, 4'd1, 8'h3C, "R2_R10");
    run(1, 4'd4, 8'h00, "R2");
    run(1, 4'd6, 8'hA5, "R2_R10");
    run(1, 4'd4, 8'h00, "R4");

    run(1, 4'd2, 8'h11, "R3_R10");
    run(1, 4'd3, 8'h00, "R3");
    run(1, 4'd5, 8'h0F, "R3_R10");
    run(1, 4'd3, 8'h00, "R3");
    run(1, 4'd4, 8'h00, "R9");

    run(1, 4'd7, 8'h00, "R5_R10");
    run(1, 4'd4, 8'h00, "R5");
    run(1, 4'd6, 8'hF0, "R2");
    run(1, 4'd5, 8'h20, "R3");
    run(1, 4'd7, 8'h00, "R5");
    run(1, 4'd4, 8'h00, "R5_wrap");

    run(1, 4'd8, 8'h00, "R6");
    run(1, 4'd4, 8'h00, "R6_or");
    run(1, 4'd6, 8'h3C, "R2");
    run(1, 4'd9, 8'h00, "R6");
    run(1, 4'd4, 8'h00, "R6_and");
    run(1, 4'd10, 8'h00, "R7");
    run(1, 4'd4, 8'h00, "R7");
    run(1, 4'd3, 8'h00, "R8");

    run(1, 4'd0, 8'h55, "R11");
    for (int c = 11; c < 16; c++) run(1, 4'(c), 8'h55, "R11");
    run(1, 4'd4, 8'h00, "R11");
    run(1, 4'd3, 8'h00, "R11");

    run(0, 4'd6, 8'h77, "R12");
    run(0, 4'd5, 8'h77, "R12");
    run(0, 4'd4, 8'h77, "R12");
    run(0, 4'd7, 8'h77, "R12");
    run(1, 4'd4, 8'h00, "R12");
    run(1, 4'd3, 8'h00, "R12");

    run(1, 4'd5, 8'h99, "R3");
    run(1, 4'd3, 8'h00, "R4");

    @(negedge clk); valid = 1'b0;
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule